// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block keeps the base mode register of a double-data-rate memory device and turns each READ or WRITE command into the stream of column addresses that the burst touches, one address per beat. A load-mode command with both bank-select bits at zero replaces the stored mode word. Any other bank-select value addresses the extended register, and the base word stays as it was. The stored word supplies the burst length, the burst ordering, the read latency and the delay-locked-loop reset request.

Each burst stays inside an aligned block of columns whose size equals the burst length. The low column bits step through the block in sequential or interleaved order, and the upper bits do not change. Reserved codes in the mode word set a sticky error flag. A burst command issued while the stored length code is reserved is refused with a one-cycle reject pulse. A new burst command cuts off the running burst, or follows it with no gap when it arrives on the last beat.

Top module: `burst_seq`

## Requirements
- R1: A load-mode command (cmdOp = 01) stores cmdMode only when cmdBank is 00. When cmdBank is 01, 10 or 11, the stored word is left unchanged, and later bursts keep the previous length and order.
- R2: Length field bits [2:0]: code 001 gives 2 beats, 010 gives 4 beats and 011 gives 8 beats. beatLast is high on the final beat only.
- R3: When bit 3 is 0 (sequential), beat k carries column {upper bits of start, (start offset + k) mod length}. The block is aligned to the length, and the start offset is the start column modulo the length.
- R4: When bit 3 is 1 (interleaved), beat k carries column {upper bits of start, start offset XOR k}.
- R5: The first beat is presented in the cycle after the command cycle, and the beats of a burst follow on consecutive cycles with beatValid high.
- R6: If the stored length code is 000 or 1xx, a read or write command produces no beats and raises cmdReject for one cycle, the cycle after the command. A load of such a code sets cfgError.
- R7: Latency field bits [6:4]: code 010 means 2 clocks (casHalf = 0) and code 110 means 2.5 clocks (casHalf = 1). Loading any other latency code sets cfgError.
- R8: Operating field bits [12:7]: all zero is normal operation. Only bit 8 set requests a delay-locked-loop reset and produces a one-cycle dllResetPulse in the cycle after the load. Any other pattern sets cfgError and produces no pulse.
- R9: cfgError stays high once set, until reset.
- R10: A burst command that arrives on the last beat starts its first beat in the next cycle with no gap. A burst command that arrives mid-burst ends the current burst and restarts at the new column.
- R11: READ (cmdOp = 10) and WRITE (cmdOp = 11) produce the same column sequence for the same mode and start column.
- R12: After reset, beatValid, beatLast, dllResetPulse, cmdReject and cfgError are low, and the stored word is all zero, so bursts are refused until a valid mode is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 2 | 01 load mode, 10 read, 11 write, 00 none |
| cmdBank | input | 2 | Bank select for load mode; 00 is the base register |
| cmdMode | input | MODE_W | Mode word for load mode |
| cmdCol | input | COL_W | Start column for read or write |
| beatValid | output | 1 | A burst beat is presented |
| beatCol | output | COL_W | Column address of the current beat |
| beatLast | output | 1 | Current beat is the last of the burst |
| casHalf | output | 1 | Stored read latency is 2.5 clocks |
| dllResetPulse | output | 1 | One-cycle delay-locked-loop reset request |
| cfgError | output | 1 | Sticky flag for a reserved code seen in a base load |
| cmdReject | output | 1 | One-cycle flag for a refused burst command |

## Verification
Every result is registered once. The first beat, dllResetPulse, cmdReject and a change in cfgError or casHalf all appear in the cycle after the command cycle, and beat k of a burst appears k cycles after the first beat. The bench drives commands on the falling edge and samples on the next falling edge, which lies after exactly one rising edge. It then steps one falling edge per beat. It sweeps every start offset within two upper-bit patterns, for each length, each order and both burst commands, and it computes each expected column from the start column, the length and the beat index.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_LOAD  = 2'b01,
    OP_READ  = 2'b10,
    OP_WRITE = 2'b11
  } cmdOp_t;

  localparam int MAX_LEN_LOG = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic                   start;
    logic                   advance;
    logic [MAX_LEN_LOG-1:0] lenMask;
    logic                   interleave;
  } seqStrobe_t;

  // length code -> offset mask (0 marks a reserved code)
  function automatic logic [MAX_LEN_LOG-1:0] lenToMask(input logic [2:0] code);
    case (code)
      3'b001:  lenToMask = 3'd1;
      3'b010:  lenToMask = 3'd3;
      3'b011:  lenToMask = 3'd7;
      default: lenToMask = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdBank,
  input  logic [MODE_W-1:0] cmdMode,
  input  logic              dpLast,
  output seqStrobe_t        strobe,
  output logic              active,
  output logic              casHalf,
  output logic              dllResetPulse,
  output logic              cfgError,
  output logic              cmdReject
);
  localparam int OPF_LO = 7;
  localparam int OPF_W  = MODE_W - OPF_LO;
  localparam logic [OPF_W-1:0] OPF_DLL = OPF_W'(2);

  logic [MODE_W-1:0] modeReg;
  logic              isLoad, isBase, isBurst, baseLoad;
  logic              lenOk, casOk, opNormal, opDll;
  logic [MAX_LEN_LOG-1:0] storedMask;
  logic              burstOk;

  always_comb begin
    isLoad     = cmdValid && (cmdOp == OP_LOAD);
    isBase     = (cmdBank == 2'b00);
    baseLoad   = isLoad && isBase;
    isBurst    = cmdValid && cmdOp[1];
    lenOk      = (lenToMask(cmdMode[2:0]) != '0);
    casOk      = (cmdMode[6:4] == 3'b010) || (cmdMode[6:4] == 3'b110);
    opNormal   = (cmdMode[MODE_W-1:OPF_LO] == '0);
    opDll      = (cmdMode[MODE_W-1:OPF_LO] == OPF_DLL);
    storedMask = lenToMask(modeReg[2:0]);
    burstOk    = (storedMask != '0);

    strobe.start      = isBurst && burstOk;
    strobe.advance    = active && !dpLast && !strobe.start;
    strobe.lenMask    = storedMask;
    strobe.interleave = modeReg[3];
  end

  assign casHalf = (modeReg[6:4] == 3'b110);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg       <= '0;
      active        <= 1'b0;
      dllResetPulse <= 1'b0;
      cfgError      <= 1'b0;
      cmdReject     <= 1'b0;
    end else begin
      if (baseLoad) modeReg <= cmdMode;
      if (strobe.start)          active <= 1'b1;
      else if (active && dpLast) active <= 1'b0;
      dllResetPulse <= baseLoad && opDll;
      cmdReject     <= isBurst && !burstOk;
      if (baseLoad && !(lenOk && casOk && (opNormal || opDll)))
        cfgError <= 1'b1;
    end
  end

  assert_ext_load_ignored_R1: assert property (@(posedge clk) disable iff (!rstN)
    (isLoad && !isBase) |=> $stable(modeReg));
  assert_start_gives_beat_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> active);
  assert_reject_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> $past(isBurst));
  assert_dll_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    dllResetPulse |-> $past(baseLoad));
  assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [COL_W-1:0] cmdCol,
  output logic [COL_W-1:0] beatCol,
  output logic             dpLast
);
  localparam int LW = MAX_LEN_LOG;

  logic [COL_W-1:0] baseCol;
  logic [LW-1:0]    mask, beatCnt, startOff, lowSeq, lowIlv, lowBits;
  logic             ilv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      mask    <= '0;
      ilv     <= 1'b0;
      beatCnt <= '0;
    end else if (strobe.start) begin
      baseCol <= cmdCol;
      mask    <= strobe.lenMask;
      ilv     <= strobe.interleave;
      beatCnt <= '0;
    end else if (strobe.advance) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    startOff = baseCol[LW-1:0] & mask;
    lowSeq   = (startOff + beatCnt) & mask;
    lowIlv   = startOff ^ beatCnt;
    lowBits  = ilv ? lowIlv : lowSeq;
    beatCol  = {baseCol[COL_W-1:LW], (baseCol[LW-1:0] & ~mask) | lowBits};
    dpLast   = (beatCnt == mask);
  end

  assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> $stable(beatCol[COL_W-1:LW]));

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdBank,
  input  logic [MODE_W-1:0] cmdMode,
  input  logic [COL_W-1:0]  cmdCol,
  output logic              beatValid,
  output logic [COL_W-1:0]  beatCol,
  output logic              beatLast,
  output logic              casHalf,
  output logic              dllResetPulse,
  output logic              cfgError,
  output logic              cmdReject
);
  seqStrobe_t strobe;
  logic       dpLast;
  logic       active;

  burst_seq_ctrl #(.MODE_W(MODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdMode(cmdMode), .dpLast(dpLast),
    .strobe(strobe), .active(active), .casHalf(casHalf),
    .dllResetPulse(dllResetPulse), .cfgError(cfgError), .cmdReject(cmdReject)
  );

  burst_seq_dp #(.COL_W(COL_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdCol(cmdCol),
    .beatCol(beatCol), .dpLast(dpLast)
  );

  assign beatValid = active;
  assign beatLast  = active && dpLast;

  assert_last_in_burst_R2: assert property (@(posedge clk) disable iff (!rstN)
    beatLast |-> beatValid);
  assert_reject_no_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReject && !$past(beatValid)) |-> !beatValid);

endmodule

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;
  localparam int COL_W = 10;
  localparam int MODE_W = 13;

  logic clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00, cmdBank = 2'b00;
  logic [MODE_W-1:0] cmdMode = '0;
  logic [COL_W-1:0] cmdCol = '0;
  logic beatValid, beatLast, casHalf, dllResetPulse, cfgError, cmdReject;
  logic [COL_W-1:0] beatCol;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  burst_seq #(.COL_W(COL_W), .MODE_W(MODE_W)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdMode(cmdMode), .cmdCol(cmdCol), .beatValid(beatValid), .beatCol(beatCol),
    .beatLast(beatLast), .casHalf(casHalf), .dllResetPulse(dllResetPulse),
    .cfgError(cfgError), .cmdReject(cmdReject));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [MODE_W-1:0] mk(input int len, input int bt, input int cas, input int opf);
    mk = {opf[5:0], cas[2:0], bt[0], len[2:0]};
  endfunction

  function automatic int expCol(input int col, input int len, input int ilv, input int k);
    int off;
    off = col % len;
    if (ilv != 0) expCol = (col - off) + (off ^ k);
    else          expCol = (col - off) + ((off + k) % len);
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive for one cycle; returns at the falling edge where the result shows
  task automatic issue(input logic [1:0] op, input logic [1:0] bank,
                       input logic [MODE_W-1:0] mode, input int col);
    cmdValid = 1'b1; cmdOp = op; cmdBank = bank; cmdMode = mode; cmdCol = col[COL_W-1:0];
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
  endtask

  task automatic walk(input string req, input int col, input int len, input int ilv);
    for (int k = 0; k < len; k++) begin
      check({req, " valid"}, int'(beatValid), 1);
      check({req, " col"}, int'(beatCol), expCol(col, len, ilv, k));
      check({req, " last"}, int'(beatLast), (k == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    check({req, " idle"}, int'(beatValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R12 reset state
    check("R12 beatValid", int'(beatValid), 0);
    check("R12 beatLast", int'(beatLast), 0);
    check("R12 dll", int'(dllResetPulse), 0);
    check("R12 cfgError", int'(cfgError), 0);
    check("R12 reject", int'(cmdReject), 0);
    issue(2'b10, 2'b00, '0, 5);
    check("R12 refused after reset", int'(cmdReject), 1);
    check("R12 no beat after reset", int'(beatValid), 0);

    // R2 R3 R4 R5 R11 sweep
    for (int ilv = 0; ilv < 2; ilv++)
      for (int lc = 1; lc <= 3; lc++) begin
        issue(2'b01, 2'b00, mk(lc, ilv, 2, 0), 0);
        check("R8 no pulse normal", int'(dllResetPulse), 0);
        for (int s = 0; s < 16; s++)
          for (int op = 2; op < 4; op++) begin
            int col;
            col = s + (s >= 8 ? 8'hA8 : 9'h150);
            issue(op[1:0], 2'b00, '0, col);
            walk(ilv != 0 ? "R4 R11 R5 ilv" : "R3 R11 R5 seq", col, 1 << lc, ilv);
          end
      end
    check("R7 no error for valid loads", int'(cfgError), 0);

    // R1 extended-register loads ignored (stored: len 4 sequential)
    issue(2'b01, 2'b00, mk(2, 0, 2, 0), 0);
    for (int b = 1; b < 4; b++) begin
      issue(2'b01, b[1:0], mk(3, 1, 6, 2), 0);
      check("R1 no dll on ext", int'(dllResetPulse), 0);
      issue(2'b10, 2'b00, '0, 13);
      walk("R1 ext ignored", 13, 4, 0);
    end
    check("R1 casHalf unchanged", int'(casHalf), 0);

    // R10 back-to-back on last beat
    issue(2'b10, 2'b00, '0, 6);
    for (int k = 0; k < 3; k++) @(negedge clk);
    check("R10 at last", int'(beatLast), 1);
    issue(2'b11, 2'b00, '0, 33);
    walk("R10 no gap", 33, 4, 0);
    // R10 truncation mid-burst
    issue(2'b10, 2'b00, '0, 9);
    @(negedge clk);
    check("R10 mid col", int'(beatCol), 10);
    issue(2'b10, 2'b00, '0, 22);
    walk("R10 truncate", 22, 4, 0);

    // R7 latency codes
    issue(2'b01, 2'b00, mk(2, 0, 6, 0), 0);
    check("R7 casHalf 2.5", int'(casHalf), 1);
    issue(2'b01, 2'b00, mk(2, 0, 2, 0), 0);
    check("R7 casHalf 2", int'(casHalf), 0);
    check("R7 still clean", int'(cfgError), 0);

    // R8 DLL reset pulse
    issue(2'b01, 2'b00, mk(3, 0, 2, 2), 0);
    check("R8 dll pulse", int'(dllResetPulse), 1);
    @(negedge clk);
    check("R8 dll one cycle", int'(dllResetPulse), 0);
    check("R8 dll not error", int'(cfgError), 0);

    issue(2'b01, 2'b00, mk(2, 0, 3, 0), 0);
    check("R7 reserved latency", int'(cfgError), 1);
    issue(2'b01, 2'b00, mk(2, 0, 2, 0), 0);
    check("R9 sticky", int'(cfgError), 1);
    doReset();
    check("R9 cleared by reset", int'(cfgError), 0);

    issue(2'b01, 2'b00, mk(2, 0, 2, 4), 0);
    check("R8 reserved op no pulse", int'(dllResetPulse), 0);
    check("R8 reserved op error", int'(cfgError), 1);

    // R6 reserved length codes
    for (int lc = 0; lc < 8; lc++) begin
      if (lc >= 1 && lc <= 3) continue;
      doReset();
      issue(2'b01, 2'b00, mk(lc, 0, 2, 0), 0);
      check("R6 error set", int'(cfgError), 1);
      issue(2'b11, 2'b00, '0, 3);
      check("R6 reject", int'(cmdReject), 1);
      check("R6 no beat", int'(beatValid), 0);
      @(negedge clk);
      check("R6 reject one cycle", int'(cmdReject), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule